// File: doc/BRIEF.md
# Pointer-Based Pseudo-LRU Victim Selector

This block picks the entry to evict in a fully associative structure, such as a small cache or a translation buffer, whose entries are numbered 0 to ENTRIES-1 (64 by default). It keeps one pointer register, and the entry that register names is the victim offered to the allocation logic when a lookup misses.

The block watches two streams of entry indices: lookup hits and fill notifications. If either stream touches the entry under the pointer, the pointer moves on to the next entry and wraps at the top. An entry that was just used is therefore not offered for eviction. An access to any other entry leaves the pointer where it is. This approximates least-recently-used order with one small register and a pair of comparators, instead of a full ordering of all entries.

The tag match and the data storage are outside the block. The surrounding logic reports the index that matched, or the index it has just filled, and reads `victim_idx` back.

Top module: `plru_victim_sel`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the pointer is loaded with 0, so `victim_idx` reads 0 after the edge.
- R2: When `hit_vld` is 1 and `hit_idx` equals `victim_idx` at a rising edge, `victim_idx` takes the value current+1 after that edge.
- R3: When `hit_vld` is 1 and `hit_idx` differs from `victim_idx`, and no fill matches, `victim_idx` keeps its value.
- R4: Advancing from entry ENTRIES-1 (63 by default) gives entry 0.
- R5: When `fill_vld` is 1 and `fill_idx` equals `victim_idx`, the pointer advances by one, exactly as for a matching hit.
- R6: When `fill_vld` is 1 and `fill_idx` differs from `victim_idx`, and no hit matches, `victim_idx` keeps its value.
- R7: A matching hit and a matching fill in the same cycle advance the pointer by exactly one entry. So does a matching hit together with a non-matching fill.
- R8: While a valid bit (`hit_vld` or `fill_vld`) is 0, its index input has no effect, even when the index equals `victim_idx`.
- R9: `victim_idx` always names an existing entry, that is, a value below ENTRIES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_vld | input | 1 | A lookup hit an entry this cycle |
| hit_idx | input | IDX_W (6) | Index of the entry that hit |
| fill_vld | input | 1 | An entry was written with a new line this cycle |
| fill_idx | input | IDX_W (6) | Index of the entry that was filled |
| victim_idx | output | IDX_W (6) | Entry to evict on the next miss |

## Verification
The pointer is the only state and it drives `victim_idx` directly, so a wrong advance decision shows at the port one clock edge after the access that caused it. An increment that is off by one, or a wrap that goes wrong, shows only at the edge where the pointer passes that value. The bench walks the pointer through every entry and across the wrap so that these faults are seen. A comparator that ignores its valid bit, or that checks the wrong source, stays hidden until an access lands on exactly the entry under the pointer. For that reason each scenario places an index equal to the current victim on the stream under test.

// File: rtl/plru_pkg.sv
// Package: shared constants and helpers for the pointer-based victim selector.
// Assumes: entry counts are at least 2.
package plru_pkg;

    // Default number of entries in the fully associative structure.
    localparam int PLRU_DEF_ENTRIES = 64;

    // Number of access sources that are watched (hit stream and fill stream).
    localparam int PLRU_NUM_SRC = 2;

    // Source slots inside the packed source vectors.
    localparam int PLRU_SRC_HIT  = 0;
    localparam int PLRU_SRC_FILL = 1;

    // Width of an index able to address n entries.
    function automatic int plru_idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/plru_match.sv
// Module: plru_match
// Compares each access source against the current pointer. The output is high
// when any valid source names the pointed-to entry.
// Assumes: sources are packed with source 0 in the low index bits.
module plru_match #(
    parameter int NSRC  = 2,
    parameter int IDX_W = 6
) (
    input  logic [NSRC-1:0]       src_vld,
    input  logic [NSRC*IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0]      ptr,
    output logic                  any_hit
);

    logic [NSRC-1:0] per_src;

    // One comparator per source, qualified by that source's valid bit.
    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        always_comb per_src[s] = src_vld[s] && (src_idx[s*IDX_W +: IDX_W] == ptr);
    end

    // Reduce the per-source comparisons to one advance request.
    always_comb any_hit = |per_src;

endmodule

// File: rtl/plru_step.sv
// Module: plru_step
// Computes the entry after the current one, wrapping from the last entry to 0.
// Assumes: cur is always below ENTRIES; ENTRIES need not be a power of two.
module plru_step #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Increment with explicit wrap at the last entry.
    always_comb nxt = (cur == LAST) ? '0 : cur + 1'b1;

endmodule

// File: rtl/plru_ptr_reg.sv
// Module: plru_ptr_reg
// Holds the victim pointer. It loads the next value when asked and clears on reset.
// Assumes: synchronous active-low reset.
module plru_ptr_reg #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] nxt,
    output logic [IDX_W-1:0] q
);

    // Pointer state: clear on reset, step on an advance request, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (adv) q <= nxt;
    end

endmodule

// File: rtl/plru_victim_sel.sv
// Module: plru_victim_sel (top)
// Pointer-based pseudo-LRU victim selector. An access (hit or fill) to the
// entry under the pointer moves the pointer on by one entry, with wrap. Any
// other access leaves it in place. Several matching accesses in one cycle
// still move it by one.
// Assumes: access indices are below ENTRIES; reset is synchronous, active low.
module plru_victim_sel
    import plru_pkg::*;
#(
    parameter int ENTRIES = PLRU_DEF_ENTRIES,
    parameter int IDX_W   = plru_idx_width(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_vld,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [PLRU_NUM_SRC-1:0]       src_vld;
    logic [PLRU_NUM_SRC*IDX_W-1:0] src_idx;
    logic                          adv;
    logic [IDX_W-1:0]              ptr_q;
    logic [IDX_W-1:0]              ptr_nxt;

    // Pack the hit and fill streams into the comparator's source vectors.
    always_comb begin
        src_vld                                 = '0;
        src_idx                                 = '0;
        src_vld[PLRU_SRC_HIT]                   = hit_vld;
        src_vld[PLRU_SRC_FILL]                  = fill_vld;
        src_idx[PLRU_SRC_HIT*IDX_W +: IDX_W]    = hit_idx;
        src_idx[PLRU_SRC_FILL*IDX_W +: IDX_W]   = fill_idx;
    end

    plru_match #(
        .NSRC  (PLRU_NUM_SRC),
        .IDX_W (IDX_W)
    ) u_match (
        .src_vld (src_vld),
        .src_idx (src_idx),
        .ptr     (ptr_q),
        .any_hit (adv)
    );

    plru_step #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_step (
        .cur (ptr_q),
        .nxt (ptr_nxt)
    );

    plru_ptr_reg #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .nxt   (ptr_nxt),
        .q     (ptr_q)
    );

    // The registered pointer is the victim seen by the allocation logic.
    always_comb victim_idx = ptr_q;

endmodule

// File: rtl/plru_victim_sel_chk.sv
// Module: plru_victim_sel_chk
// Port-level checker for plru_victim_sel, bound to every instance.
// Assumes: same parameters as the bound instance.
module plru_victim_sel_chk #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit_vld,
    input logic [IDX_W-1:0] hit_idx,
    input logic             fill_vld,
    input logic [IDX_W-1:0] fill_idx,
    input logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic hit_on_ptr;
    logic fill_on_ptr;

    // Which streams touch the pointed-to entry this cycle.
    always_comb begin
        hit_on_ptr  = hit_vld  && (hit_idx  == victim_idx);
        fill_on_ptr = fill_vld && (fill_idx == victim_idx);
    end

    // R1: reset loads entry 0.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (victim_idx == '0));

    // R2: a matching hit steps the pointer to the next entry (wrap excluded).
    assert_hit_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_on_ptr && victim_idx != LAST) |=> (victim_idx == $past(victim_idx) + 1'b1));

    // R4: stepping from the last entry gives entry 0.
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_on_ptr || fill_on_ptr) && victim_idx == LAST) |=> (victim_idx == '0));

    // R5 and R7: a matching fill, alone or with a matching hit, steps by one.
    assert_fill_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_on_ptr && victim_idx != LAST) |=> (victim_idx == $past(victim_idx) + 1'b1));

    // R3, R6, R8: with no matching access the pointer holds.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_on_ptr && !fill_on_ptr) |=> $stable(victim_idx));

    // R9: the victim always names an existing entry.
    assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_idx <= LAST);

endmodule

bind plru_victim_sel plru_victim_sel_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
) u_plru_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_vld    (hit_vld),
    .hit_idx    (hit_idx),
    .fill_vld   (fill_vld),
    .fill_idx   (fill_idx),
    .victim_idx (victim_idx)
);

// File: tb/tb_plru_victim_sel.sv
`timescale 1ns/1ps
// Directed bench for plru_victim_sel: one task per scenario.
module tb_plru_victim_sel;

    localparam int ENTRIES = 64;
    localparam int IDX_W   = 6;
    localparam int WDOG    = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hit_vld = 1'b0;
    logic [IDX_W-1:0] hit_idx = '0;
    logic             fill_vld = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [IDX_W-1:0] victim_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int exp_ptr = 0;
    bit done    = 1'b0;

    plru_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .hit_vld(hit_vld), .hit_idx(hit_idx),
        .fill_vld(fill_vld), .fill_idx(fill_idx),
        .victim_idx(victim_idx)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    task automatic check(input string req, input int exp);
        n_tests++;
        if (int'(victim_idx) != exp) begin
            n_fail++;
            $display("FAIL %s: victim_idx=%0d expected=%0d", req, victim_idx, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the model from the rules, check after the edge.
    task automatic access(input bit hv, input int hi, input bit fv, input int fi, input string req);
        @(negedge clk);
        hit_vld = hv; hit_idx = IDX_W'(hi);
        fill_vld = fv; fill_idx = IDX_W'(fi);
        if ((hv && hi == exp_ptr) || (fv && fi == exp_ptr))
            exp_ptr = (exp_ptr == ENTRIES - 1) ? 0 : exp_ptr + 1;
        @(negedge clk);
        hit_vld = 1'b0; fill_vld = 1'b0;
        check(req, exp_ptr);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_ptr = 0;
        check("R1 reset", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 0);
    endtask

    task automatic t_hit_on_ptr;
        access(1, exp_ptr, 0, 0, "R2 hit on pointer");
        access(1, exp_ptr, 0, 0, "R2 second hit on pointer");
    endtask

    task automatic t_hit_elsewhere;
        access(1, 40, 0, 0, "R3 hit elsewhere");
        access(1, exp_ptr + 1, 0, 0, "R3 hit on next entry");
    endtask

    task automatic t_invalid_ignored;
        access(0, exp_ptr, 0, 0, "R8 hit index without valid");
        access(0, 0, 0, exp_ptr, "R8 fill index without valid");
    endtask

    task automatic t_fill;
        access(0, 0, 1, exp_ptr, "R5 fill on pointer");
        access(0, 0, 1, (exp_ptr + 7) % ENTRIES, "R6 fill elsewhere");
    endtask

    task automatic t_both;
        access(1, exp_ptr, 1, exp_ptr, "R7 hit and fill on pointer");
        access(1, exp_ptr, 1, (exp_ptr + 3) % ENTRIES, "R7 matching hit, other fill");
        access(1, (exp_ptr + 5) % ENTRIES, 1, exp_ptr, "R7 other hit, matching fill");
    endtask

    task automatic t_walk_wrap;
        while (exp_ptr != ENTRIES - 1)
            access(1, exp_ptr, 0, 0, "R9 walk through entries");
        check("R4 at last entry", ENTRIES - 1);
        access(1, ENTRIES - 1, 0, 0, "R4 wrap by hit");
        access(1, 1, 0, 0, "R3 hold at 0 after wrap");
    endtask

    task automatic t_wrap_fill;
        while (exp_ptr != ENTRIES - 1)
            access(0, 0, 1, exp_ptr, "R5 walk by fills");
        access(1, ENTRIES - 1, 1, ENTRIES - 1, "R4 R7 wrap by both");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_hit_on_ptr();
        t_hit_elsewhere();
        t_invalid_ignored();
        t_fill();
        t_both();
        t_walk_wrap();
        t_wrap_fill();
        // Reset in the middle of a run returns the pointer to 0.
        access(1, exp_ptr, 0, 0, "R2 before mid-run reset");
        t_reset();
        finish_run();
    end

endmodule